// File: doc/BRIEF.md
# SGMII Link Recovery Sequencer

This block brings up an SGMII link between a MAC and its PHY and recovers it when the link hangs. Software would otherwise have to run the procedure with delay loops. A single start pulse launches the sequence. The block then acts as the only master on a simple 32-bit register bus that reaches the SGMII control block.

The sequence runs in four parts:
- It reads the auto-negotiation status register. If the ability bit is clear, it finishes at once.
- It clears the reset register and then releases the five active-low clock-domain resets one at a time, in a fixed order. Each release is a read-modify-write.
- It repeatedly pulses the PHY reset bit in the auto-negotiation control register. After every pulse it samples the transmit-state field of the debug register.
- It stops when that field shows a good state, or when the attempt limit is reached.

All waits are counted in clock cycles. The cycle counts are derived from a clock-frequency parameter and a divisor. The divisor shortens the waits when the block is simulated.

Top module: `sgmii_recovery_seq`

## Requirements
- R1: After an accepted start, the first bus access is a read of byte offset 0x20. If bit 3 of the returned word is 0, the block:
  - pulses `done`;
  - sets `skipped` to 1 and leaves `attempts` at 0;
  - makes no other bus access.
- R2: When bit 3 is 1, the block writes 0x00000000 to offset 0x14 and then reads offset 0x14. It then waits the 10 µs delay.
- R3: The block releases the reset bits of offset 0x14 in the order bit 4, bit 2, bit 3, bit 0, bit 1. Each release is done as follows, and every other bit of the register is preserved:
  - read offset 0x14;
  - write back the read value with that one bit set;
  - read offset 0x14 once more as a dummy read;
  - wait the 10 µs delay.
- R4: Each recovery attempt runs these steps in order:
  - a read-modify-write on offset 0x1C that ORs in bits 15 and 12, followed by a dummy read and the 200 µs delay;
  - a read-modify-write on offset 0x1C that clears only bit 15, followed by a dummy read and the 300 ms delay;
  - a read of offset 0x58.
- R5: An attempt succeeds when bits 7:0 of the word read from offset 0x58 equal 0x0F or 0x10. The upper bits are ignored. On success, `done` pulses, `fail` stays 0, and `attempts` shows the number of attempts made, counting the successful one.
- R6: With the default retry limit of 20, at most 21 attempts are made. If the 21st sample is not good, the block:
  - pulses `done`;
  - sets `fail` to 1;
  - shows 21 on `attempts`.
- R7: Each delay lasts max(1, floor(µs × CLK_HZ / 1e6 / DELAY_DIV)) cycles. No bus request is raised while a delay is running. The gap from the last access before a delay to the next request is at least the delay length, and at most the delay length plus 8 cycles.
- R8: Only one bus request is outstanding at a time. While `bus_valid` is high and `bus_ready` is low, the address, the write data and the direction stay stable. An access completes in the cycle in which `bus_valid` and `bus_ready` are both high. Read data is taken in that same cycle.
- R9: A start pulse that arrives while `busy` is high has no effect. It does not restart the sequence and does not add bus accesses.
- R10: `done` is high for exactly one cycle per run.
  - `fail`, `skipped` and `attempts` hold their values until the next accepted start, which clears them.
  - A synchronous `rst` returns the block to idle and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; ignored while busy |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Bus accepts the request (read data valid with it) |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Retry limit exhausted |
| skipped | output | 1 | Auto-negotiation ability absent, sequence skipped |
| attempts | output | ATT_W | Number of recovery attempts made |

## Verification
The bench runs the sequence against a register responder. The runs differ in two things: the status word, which has the ability bit either clear or set, and the script of debug words the responder returns. The runs are:
- a skipped run;
- a run that succeeds on its first sample, with the upper bits of the debug word set;
- a run that succeeds on its third sample, after samples of 0x1F and 0x00 in the low byte;
- a run that exhausts all 21 attempts;
- a run whose good sample comes after 0x0E and 0x11, which are one below 0x0F and one above 0x10.

These runs separate a correct decode of the good values from one that reads the wrong field, uses the wrong values, or tests a range. The runs also separate a correct retry limit from one that is off by one.

Each run uses a different responder latency, which tests that requests are held correctly. A scoreboard compares every access against the expected sequence. This catches:
- a wrong release order;
- a lost bit during read-modify-write;
- a missing dummy read;
- an extra run caused by a start pulse arriving mid-run.

// File: rtl/sgrec_pkg.sv
package sgrec_pkg;

  localparam logic [7:0] OFF_RESET  = 8'h14;
  localparam logic [7:0] OFF_ANCTL  = 8'h1C;
  localparam logic [7:0] OFF_ANSTAT = 8'h20;
  localparam logic [7:0] OFF_DEBUG  = 8'h58;

  localparam int unsigned ABILITY_BIT = 3;
  localparam int unsigned PHYRST_BIT  = 15;
  localparam int unsigned ANEN_BIT    = 12;
  localparam logic [7:0]  GOOD_TX_A   = 8'h0F;
  localparam logic [7:0]  GOOD_TX_B   = 8'h10;
  localparam int unsigned NUM_STAGES  = 5;

  // Release order of the active-low reset bits; the order itself is behaviour.
  function automatic int unsigned stage_bit(input int unsigned k);
    case (k)
      0:       return 4;
      1:       return 2;
      2:       return 3;
      3:       return 0;
      default: return 1;
    endcase
  endfunction

  function automatic longint unsigned dly_cycles(input longint unsigned us,
                                                 input longint unsigned hz,
                                                 input longint unsigned div);
    longint unsigned c;
    c = (us * hz) / 64'd1000000 / div;
    return (c == 0) ? 64'd1 : c;
  endfunction

  typedef enum logic [3:0] {
    S_IDLE, S_STAT_RD, S_CLR_WR, S_CLR_RB, S_WAIT,
    S_RMW_RD, S_RMW_WR, S_RMW_RB, S_DBG_RD
  } seq_state_t;

  typedef enum logic [1:0] {PH_PRE, PH_STAGE, PH_ASET, PH_ACLR} seq_phase_t;

endpackage

// File: rtl/sgrec_bus_master.sv
module sgrec_bus_master #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cmd_done  <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (bus_valid && bus_ready) begin
        bus_valid <= 1'b0;
        cmd_rdata <= bus_rdata;
        cmd_done  <= 1'b1;
      end else if (cmd_go && !bus_valid) begin
        bus_valid <= 1'b1;
        bus_write <= cmd_write;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end

  // R8: request held stable until accepted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_write)));

  // R8: sequencer never issues while a request is outstanding
  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !cmd_go);

endmodule

// File: rtl/sgrec_timer.sv
module sgrec_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          running,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) expired <= 1'b1;
      end
    end
  end

  assign running = (cnt != '0);

  // R7: a delay is never restarted while one is running
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
    load |-> (!running && load_val != '0));

endmodule

// File: rtl/sgmii_recovery_seq.sv
module sgmii_recovery_seq #(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned DELAY_DIV = 1,
  parameter int unsigned MAX_RETRY = 20,
  parameter int          AW        = 8,
  localparam int ATT_W = $clog2(MAX_RETRY + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             bus_valid,
  output logic             bus_write,
  output logic [AW-1:0]    bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ready,
  input  logic [31:0]      bus_rdata,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             skipped,
  output logic [ATT_W-1:0] attempts
);
  import sgrec_pkg::*;

  localparam int DW = 32;
  localparam longint unsigned T10  = dly_cycles(64'd10,     64'(CLK_HZ), 64'(DELAY_DIV));
  localparam longint unsigned T200 = dly_cycles(64'd200,    64'(CLK_HZ), 64'(DELAY_DIV));
  localparam longint unsigned T300 = dly_cycles(64'd300000, 64'(CLK_HZ), 64'(DELAY_DIV));
  localparam int CNT_W = $clog2(T300 + 1);
  localparam int MAX_ATT = MAX_RETRY + 1;
  localparam logic [DW-1:0] ASET_MASK = (DW'(1) << PHYRST_BIT) | (DW'(1) << ANEN_BIT);
  localparam logic [DW-1:0] ACLR_MASK = DW'(1) << PHYRST_BIT;

  seq_state_t      state;
  seq_phase_t      phase;
  logic            issued;
  logic [2:0]      stage_q;
  logic [DW-1:0]   rmw_mask;
  logic            rmw_set;

  logic            cmd_go, cmd_write, cmd_done;
  logic [AW-1:0]   cmd_addr, rmw_addr;
  logic [DW-1:0]   cmd_wdata, cmd_rdata;
  logic            tmr_load, tmr_running, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic [ATT_W-1:0] nxt_att;
  logic            tx_good;

  assign rmw_addr = (phase == PH_STAGE) ? AW'(OFF_RESET) : AW'(OFF_ANCTL);
  assign nxt_att  = attempts + 1'b1;
  assign tx_good  = (cmd_rdata[7:0] == GOOD_TX_A) || (cmd_rdata[7:0] == GOOD_TX_B);

  always_comb begin
    cmd_go    = 1'b0;
    cmd_write = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    tmr_load  = 1'b0;
    tmr_val   = CNT_W'(T10);
    case (state)
      S_STAT_RD: begin cmd_go = !issued; cmd_addr = AW'(OFF_ANSTAT); end
      S_CLR_WR:  begin cmd_go = !issued; cmd_write = 1'b1; cmd_addr = AW'(OFF_RESET); end
      S_CLR_RB:  begin cmd_go = !issued; cmd_addr = AW'(OFF_RESET); end
      S_RMW_RD:  begin cmd_go = !issued; cmd_addr = rmw_addr; end
      S_RMW_WR: begin
        cmd_go    = !issued;
        cmd_write = 1'b1;
        cmd_addr  = rmw_addr;
        cmd_wdata = rmw_set ? (cmd_rdata | rmw_mask) : (cmd_rdata & ~rmw_mask);
      end
      S_RMW_RB:  begin cmd_go = !issued; cmd_addr = rmw_addr; end
      S_DBG_RD:  begin cmd_go = !issued; cmd_addr = AW'(OFF_DEBUG); end
      S_WAIT: begin
        tmr_load = !issued;
        case (phase)
          PH_ASET: tmr_val = CNT_W'(T200);
          PH_ACLR: tmr_val = CNT_W'(T300);
          default: tmr_val = CNT_W'(T10);
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      phase    <= PH_PRE;
      issued   <= 1'b0;
      stage_q  <= '0;
      rmw_mask <= '0;
      rmw_set  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      skipped  <= 1'b0;
      attempts <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          busy     <= 1'b1;
          fail     <= 1'b0;
          skipped  <= 1'b0;
          attempts <= '0;
          issued   <= 1'b0;
          state    <= S_STAT_RD;
        end
      end else if (!issued) begin
        issued <= 1'b1;
      end else if (state == S_WAIT) begin
        if (tmr_exp) begin
          issued <= 1'b0;
          state  <= S_RMW_RD;
          case (phase)
            PH_PRE: begin
              stage_q  <= '0;
              rmw_mask <= DW'(1) << stage_bit(0);
              rmw_set  <= 1'b1;
              phase    <= PH_STAGE;
            end
            PH_STAGE: begin
              if (stage_q == 3'(NUM_STAGES - 1)) begin
                rmw_mask <= ASET_MASK;
                rmw_set  <= 1'b1;
                phase    <= PH_ASET;
              end else begin
                stage_q  <= stage_q + 1'b1;
                rmw_mask <= DW'(1) << stage_bit(32'(stage_q) + 1);
              end
            end
            PH_ASET: begin
              rmw_mask <= ACLR_MASK;
              rmw_set  <= 1'b0;
              phase    <= PH_ACLR;
            end
            default: state <= S_DBG_RD;
          endcase
        end
      end else if (cmd_done) begin
        issued <= 1'b0;
        case (state)
          S_STAT_RD: begin
            if (!cmd_rdata[ABILITY_BIT]) begin
              skipped <= 1'b1;
              done    <= 1'b1;
              busy    <= 1'b0;
              state   <= S_IDLE;
            end else begin
              state <= S_CLR_WR;
            end
          end
          S_CLR_WR: state <= S_CLR_RB;
          S_CLR_RB: begin state <= S_WAIT; phase <= PH_PRE; end
          S_RMW_RD: state <= S_RMW_WR;
          S_RMW_WR: state <= S_RMW_RB;
          S_RMW_RB: state <= S_WAIT;
          S_DBG_RD: begin
            attempts <= nxt_att;
            if (tx_good || nxt_att == ATT_W'(MAX_ATT)) begin
              fail  <= !tx_good;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              rmw_mask <= ASET_MASK;
              rmw_set  <= 1'b1;
              phase    <= PH_ASET;
              state    <= S_RMW_RD;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  sgrec_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  sgrec_timer #(.CW(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .running(tmr_running), .expired(tmr_exp)
  );

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: failure only with the full attempt count
  assert_fail_count_R6: assert property (@(posedge clk) disable iff (rst)
    fail |-> (attempts == ATT_W'(MAX_ATT) && !skipped));

  // R6: attempt counter never passes the limit
  assert_att_bound_R6: assert property (@(posedge clk) disable iff (rst)
    attempts <= ATT_W'(MAX_ATT));

  // R1: a skipped run made no attempts
  assert_skip_no_att_R1: assert property (@(posedge clk) disable iff (rst)
    skipped |-> (attempts == '0));

  // R7: bus stays quiet while a delay runs
  assert_quiet_delay_R7: assert property (@(posedge clk) disable iff (rst)
    tmr_running |-> !bus_valid);

endmodule

// File: tb/sgmii_recovery_seq_tb.sv
module sgmii_recovery_seq_tb_top;

  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int unsigned DIV    = 25_000;
  localparam longint T300 = (64'd300000 * CLK_HZ) / 64'd1000000 / DIV;
  localparam int ATT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic bus_valid, bus_write, bus_ready;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic busy, done, fail, skipped;
  logic [ATT_W-1:0] attempts;

  always #4 clk = ~clk;

  sgmii_recovery_seq #(.CLK_HZ(CLK_HZ), .DELAY_DIV(DIV), .MAX_RETRY(20), .AW(8)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .fail(fail), .skipped(skipped), .attempts(attempts)
  );

  typedef struct { bit wr; logic [7:0] addr; logic [31:0] data; } txn_t;
  txn_t exp_q[$];
  logic [31:0] dbg_q[$];

  int errors = 0;
  int checks = 0;
  longint cyc = 0;
  longint last_hs = 0;
  int lat = 0;
  int wcnt = 0;
  int done_cnt = 0;
  bit prev_valid = 1'b0;
  logic [31:0] rst_m = 32'hAAAA;
  logic [31:0] ctrl_m = 32'h0140;
  logic [31:0] stat_m = 32'h0;
  int ord[5] = '{4, 2, 3, 0, 1};

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input bit wr, input logic [7:0] a, input logic [31:0] d);
    txn_t t;
    t.wr = wr; t.addr = a; t.data = d;
    exp_q.push_back(t);
  endtask

  // Driver side of the scoreboard: expected access stream for one run
  task automatic push_run(input bit an_ok, input int n_att);
    logic [31:0] v, c;
    push(0, 8'h20, 0);
    if (!an_ok) return;
    push(1, 8'h14, 32'h0);
    push(0, 8'h14, 0);
    v = 0;
    for (int i = 0; i < 5; i++) begin
      push(0, 8'h14, 0);
      v = v | (32'h1 << ord[i]);
      push(1, 8'h14, v);
      push(0, 8'h14, 0);
    end
    c = ctrl_m;
    for (int k = 0; k < n_att; k++) begin
      push(0, 8'h1C, 0);
      c = c | 32'h9000;
      push(1, 8'h1C, c);
      push(0, 8'h1C, 0);
      push(0, 8'h1C, 0);
      c = c & ~32'h8000;
      push(1, 8'h1C, c);
      push(0, 8'h1C, 0);
      push(0, 8'h58, 0);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (done) done_cnt++;

  // Register responder and monitor side of the scoreboard
  always @(negedge clk) begin
    if (bus_valid && !prev_valid && exp_q.size() > 0 &&
        !exp_q[0].wr && exp_q[0].addr == 8'h58)
      chk((cyc - last_hs) >= T300 && (cyc - last_hs) <= T300 + 8,
          "R7 300ms gap", cyc - last_hs, T300);
    if (bus_ready) begin
      bus_ready = 1'b0;
    end else if (bus_valid) begin
      if (wcnt >= lat) begin
        txn_t t;
        wcnt = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected access", bus_addr, 0);
        end else begin
          t = exp_q.pop_front();
          chk(bus_write == t.wr && bus_addr == t.addr, "R3/R4 access kind/addr",
              {bus_write, bus_addr}, {t.wr, t.addr});
          if (t.wr) chk(bus_wdata == t.data, "R3/R4 write data", bus_wdata, t.data);
        end
        if (bus_write) begin
          if (bus_addr == 8'h14) rst_m = bus_wdata;
          else if (bus_addr == 8'h1C) ctrl_m = bus_wdata;
          bus_rdata = 32'h0;
        end else begin
          case (bus_addr)
            8'h14: bus_rdata = rst_m;
            8'h1C: bus_rdata = ctrl_m;
            8'h20: bus_rdata = stat_m;
            8'h58: bus_rdata = (dbg_q.size() > 0) ? dbg_q.pop_front() : 32'h0000_0005;
            default: bus_rdata = 32'hDEAD_BEEF;
          endcase
        end
        bus_ready = 1'b1;
        last_hs = cyc;
      end else begin
        wcnt++;
      end
    end
    prev_valid = bus_valid;
  end

  always @(negedge clk) begin
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int extra_start_at);
    int n;
    done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n == extra_start_at) begin
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10 done one cycle", done_cnt, 1);
    chk(exp_q.size() == 0, "R1/R9 all expected accesses seen", exp_q.size(), 0);
    chk(busy == 0, "R10 idle after run", busy, 0);
  endtask

  initial begin
    bus_ready = 1'b0;
    bus_rdata = 32'h0;
    repeat (4) @(negedge clk);
    chk({busy, done, fail, skipped, attempts, bus_valid} == 0, "R10 reset state",
        {busy, done, fail, skipped, attempts, bus_valid}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: ability bit 3 clear
    stat_m = 32'h0000_0037;
    lat = 1;
    push_run(0, 0);
    run(-1);
    chk(skipped == 1 && fail == 0 && attempts == 0, "R1 skipped flags",
        {skipped, fail, attempts}, {1'b1, 1'b0, 5'd0});
    chk(rst_m == 32'hAAAA && ctrl_m == 32'h0140, "R1 registers untouched",
        {rst_m, ctrl_m}, {32'hAAAA, 32'h0140});

    // R2 R3 R4 R5: success on first sample, upper debug bits ignored
    stat_m = 32'h0000_0008;
    lat = 0;
    dbg_q = '{32'hABCD_120F};
    push_run(1, 1);
    run(-1);
    chk(fail == 0 && skipped == 0 && attempts == 1, "R5 first attempt good",
        {fail, skipped, attempts}, {1'b0, 1'b0, 5'd1});
    chk(rst_m == 32'h1F, "R3 all resets released", rst_m, 32'h1F);

    // R5: 0x1F and 0x00 are bad, 0x10 good on third
    lat = 2;
    dbg_q = '{32'h0000_001F, 32'h0000_0F00, 32'h1234_5610};
    push_run(1, 3);
    run(-1);
    chk(fail == 0 && attempts == 3, "R5 third attempt good", {fail, attempts}, {1'b0, 5'd3});
    chk(ctrl_m == 32'h1140, "R4 phy reset cleared, AN enable kept", ctrl_m, 32'h1140);

    // R6: never good -> 21 attempts, fail
    lat = 1;
    dbg_q.delete();
    push_run(1, 21);
    run(-1);
    chk(fail == 1 && attempts == 21, "R6 retry limit", {fail, attempts}, {1'b1, 5'd21});
    chk(skipped == 0, "R6 not skipped", skipped, 0);

    // R9 R10: start while busy ignored; flags cleared by new start; neighbours of good values
    lat = 3;
    dbg_q = '{32'h0000_000E, 32'h0000_0011, 32'h0000_000F};
    push_run(1, 3);
    run(120);
    chk(fail == 0 && attempts == 3, "R9 mid-run start ignored, R10 flags cleared",
        {fail, attempts}, {1'b0, 5'd3});

    // R10: reset clears held outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({busy, done, fail, skipped, attempts} == 0, "R10 reset clears outputs",
        {busy, done, fail, skipped, attempts}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule